// File: doc/BRIEF.md
# UART Variant Probe Sequencer

This block is a small bus master that shares an 8-bit register bus with a PC-compatible serial port controller. When it is started, it issues a fixed sequence of register writes and read-backs, then classifies the attached controller from how it answers. It finishes by reporting a 4-bit type code together with a one-cycle completion pulse. Baud setup, message printing and the serial controller itself are outside the block.

The bus uses synchronous, single-cycle strobes: one write strobe or one read strobe per cycle, with a 3-bit register address. Read data is returned on `bus_rdata` in the cycle after the read strobe. The bus has no back-pressure: the responder must answer every read in the following cycle, and the sequencer never stalls a strobe. `start`, `busy`, `done` and `type_out` are plain control and status pins.

Classification walks a decision tree, and the first test that decides ends the run. The tests in order are: whether the divisor latch holds its value, whether it aliases the interrupt-enable register, whether a scratch register exists, whether scratch is hidden under the enhanced-access line-control value, the FIFO identification bits, and whether the modem-control register keeps bit 5. Type codes: 0 absent, 1 basic without scratch, 2 no FIFO, 3 faulty FIFO, 4 working 16-byte FIFO, 5 FIFO with automatic flow control, 6 enhanced feature register, 7 64-byte FIFO, 8 extended enhanced. Code 8 is defined, but no read-back signature produces it.

Top module: `uvp_probe`

## Requirements
- R1: After reset, `busy`, `done`, `bus_rd` and `bus_wr` are low and `type_out` is 0. While `busy` is low, no strobe is issued.
- R2: A `start` sampled while idle raises `busy` in the next cycle. Each write takes one cycle and each read takes two. The ops, as (register address, value), are: write 1=0x00, write 3=0x80, write 1=0x5A, read 1, write 3=0x00, read 1, write 7=0x5A, read 7, write 3=0xBF, read 7, write 3=0x80, write 2=0xE7, read 2, write 4=0x20, read 4. The run stops after the first read that decides.
- R3: If the first read of address 1 is not 0x5A, the result is 0.
- R4: If the second read of address 1 returns 0x5A, the result is 0.
- R5: If the first read of address 7 is not 0x5A, the result is 1.
- R6: If the second read of address 7 is not 0x5A, the result is 6.
- R7: For the read of address 2, the checks are made in this priority order: bit 6 clear gives 2, then bit 7 clear gives 3, then bit 5 set gives 7. Otherwise the probe continues.
- R8: For the read of address 4, bit 5 set gives 5 and bit 5 clear gives 4.
- R9: `done` is high for exactly one cycle, two cycles after the deciding read strobe, and `busy` is low in that cycle. `type_out` changes only in that cycle and then holds through the next run until that run completes.
- R10: A `start` pulse while `busy` is high has no effect on the op sequence or the result.
- R11: At most one strobe is active in any cycle. The cycle after a read strobe carries no strobe. `bus_wdata` is 0x00 in any cycle without a write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a probe run when idle |
| busy | output | 1 | Probe run in progress |
| done | output | 1 | One-cycle completion pulse |
| type_out | output | 4 | Classification result |
| bus_wr | output | 1 | Register write strobe |
| bus_rd | output | 1 | Register read strobe |
| bus_addr | output | 3 | Register address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid the cycle after `bus_rd` |

## Verification
The bench drives responders whose identification bits conflict, for example bit 5 set together with bit 6 or bit 7 clear. A design that tests the bits in the wrong order would report 7 instead of 2 or 3. Other responders alias the divisor to the interrupt-enable register or hide scratch only under the enhanced line-control value. A design that sampled read data in the strobe cycle, or that failed to stop at the first deciding read, would show misplaced or extra bus ops in the per-cycle comparison. A second start in the middle of a run, and `type_out` while the next run is in progress, expose a design that restarts on a busy start or clears its result too early.

// File: rtl/uvp_pkg.sv
package uvp_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int CODE_W = 4;
  localparam int STEP_COUNT = 15;
  localparam int STEP_W = $clog2(STEP_COUNT);

  // register offsets (the attached controller decodes these)
  localparam logic [ADDR_W-1:0] RA_IEN  = 3'd1;  // interrupt enable / divisor high
  localparam logic [ADDR_W-1:0] RA_FIFO = 3'd2;  // FIFO control write / ident read
  localparam logic [ADDR_W-1:0] RA_LINE = 3'd3;
  localparam logic [ADDR_W-1:0] RA_MODM = 3'd4;
  localparam logic [ADDR_W-1:0] RA_SCR  = 3'd7;

  typedef enum logic [CODE_W-1:0] {
    VT_ABSENT = 4'd0, VT_NOSCR = 4'd1, VT_NOFIFO = 4'd2, VT_BADFIFO = 4'd3,
    VT_FIFO16 = 4'd4, VT_FLOWCTL = 4'd5, VT_ENHREG = 4'd6, VT_FIFO64 = 4'd7,
    VT_ENHX = 4'd8
  } vtype_t;

  typedef struct packed {
    logic              is_rd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } bus_op_t;
endpackage

// File: rtl/uvp_step_rom.sv
module uvp_step_rom
  import uvp_pkg::*;
#(
  parameter logic [DATA_W-1:0] PATTERN = 8'h5A
) (
  input  logic [STEP_W-1:0] step,
  output bus_op_t           op
);
  function automatic bus_op_t wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    return '{is_rd: 1'b0, addr: a, data: d};
  endfunction
  function automatic bus_op_t rd(input logic [ADDR_W-1:0] a);
    return '{is_rd: 1'b1, addr: a, data: '0};
  endfunction

  always_comb begin
    case (step)
      4'd0:    op = wr(RA_IEN, 8'h00);
      4'd1:    op = wr(RA_LINE, 8'h80);
      4'd2:    op = wr(RA_IEN, PATTERN);
      4'd3:    op = rd(RA_IEN);
      4'd4:    op = wr(RA_LINE, 8'h00);
      4'd5:    op = rd(RA_IEN);
      4'd6:    op = wr(RA_SCR, PATTERN);
      4'd7:    op = rd(RA_SCR);
      4'd8:    op = wr(RA_LINE, 8'hBF);
      4'd9:    op = rd(RA_SCR);
      4'd10:   op = wr(RA_LINE, 8'h80);
      4'd11:   op = wr(RA_FIFO, 8'hE7);
      4'd12:   op = rd(RA_FIFO);
      4'd13:   op = wr(RA_MODM, 8'h20);
      4'd14:   op = rd(RA_MODM);
      default: op = rd(RA_MODM);
    endcase
  end
endmodule

// File: rtl/uvp_judge.sv
module uvp_judge
  import uvp_pkg::*;
#(
  parameter logic [DATA_W-1:0] PATTERN = 8'h5A
) (
  input  logic [STEP_W-1:0] step,
  input  logic [DATA_W-1:0] rdata,
  output logic              decided,
  output vtype_t            verdict
);
  always_comb begin
    decided = 1'b0;
    verdict = VT_ABSENT;
    case (step)
      4'd3: decided = (rdata != PATTERN);
      4'd5: decided = (rdata == PATTERN);
      4'd7: begin decided = (rdata != PATTERN); verdict = VT_NOSCR; end
      4'd9: begin decided = (rdata != PATTERN); verdict = VT_ENHREG; end
      4'd12: begin
        if (!rdata[6])      begin decided = 1'b1; verdict = VT_NOFIFO;  end
        else if (!rdata[7]) begin decided = 1'b1; verdict = VT_BADFIFO; end
        else if (rdata[5])  begin decided = 1'b1; verdict = VT_FIFO64;  end
      end
      4'd14: begin
        decided = 1'b1;
        verdict = rdata[5] ? VT_FLOWCTL : VT_FIFO16;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/uvp_probe.sv
module uvp_probe
  import uvp_pkg::*;
#(
  parameter logic [DATA_W-1:0] PATTERN = 8'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [CODE_W-1:0] type_out,
  output logic              bus_wr,
  output logic              bus_rd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_EVAL} state_t;

  state_t            state_q;
  logic [STEP_W-1:0] step_q;
  logic              done_q;
  vtype_t            type_q;
  bus_op_t           op;
  logic              decided;
  vtype_t            verdict;

  uvp_step_rom #(.PATTERN(PATTERN)) u_rom (.step(step_q), .op(op));
  uvp_judge #(.PATTERN(PATTERN)) u_judge (
    .step(step_q), .rdata(bus_rdata), .decided(decided), .verdict(verdict)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      step_q  <= '0;
      done_q  <= 1'b0;
      type_q  <= VT_ABSENT;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: if (start) begin
          state_q <= S_ISSUE;
          step_q  <= '0;
        end
        S_ISSUE: begin
          if (op.is_rd) state_q <= S_EVAL;
          else          step_q  <= step_q + 1'b1;
        end
        S_EVAL: begin
          if (decided) begin
            state_q <= S_IDLE;
            done_q  <= 1'b1;
            type_q  <= verdict;
          end else begin
            state_q <= S_ISSUE;
            step_q  <= step_q + 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != S_IDLE);
  assign done      = done_q;
  assign type_out  = type_q;
  assign bus_wr    = (state_q == S_ISSUE) && !op.is_rd;
  assign bus_rd    = (state_q == S_ISSUE) && op.is_rd;
  assign bus_addr  = op.addr;
  assign bus_wdata = bus_wr ? op.data : '0;
endmodule

// File: rtl/uvp_probe_chk.sv
module uvp_probe_chk
  import uvp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [CODE_W-1:0] type_out,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata
);
  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_rd && !bus_wr));
  assert_first_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(busy)) |-> (bus_wr && bus_addr == 3'd1 && bus_wdata == 8'h00));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_ends_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  assert_type_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(type_out));
  assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));
  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));
  assert_read_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> (!bus_rd && !bus_wr));
  assert_code_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (type_out <= 4'd7));
endmodule

bind uvp_probe uvp_probe_chk u_chk (.*);

// File: tb/uvp_probe_bench.sv
`timescale 1ns/1ps
module uvp_probe_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       busy, done, bus_wr, bus_rd;
  logic [3:0] type_out;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata = 8'h00;

  int checks = 0;
  int errors = 0;
  int variant = 0;

  always #2.5 clk = ~clk;

  uvp_probe u_uvp_probe (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .type_out(type_out), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // behavioural responders: 1..7 as coded, 9 absent, 10 aliased divisor,
  // 11 ident 0x61 (expect 3), 12 ident 0x21 (expect 2)
  logic [7:0] m_line = 8'h00, m_ien = 8'h00, m_div = 8'h00, m_scr = 8'h00, m_modm = 8'h00;

  function automatic logic [7:0] ident_of(input int v);
    case (v)
      2: return 8'h01;
      3: return 8'h41;
      7: return 8'hE1;
      11: return 8'h61;
      12: return 8'h21;
      default: return 8'hC1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (bus_wr) begin
      case (bus_addr)
        3'd1: if (variant != 10 && m_line[7]) m_div <= bus_wdata; else m_ien <= bus_wdata;
        3'd3: m_line <= bus_wdata;
        3'd4: m_modm <= (variant == 5) ? bus_wdata : (bus_wdata & 8'h1F);
        3'd7: m_scr <= bus_wdata;
        default: ;
      endcase
    end
    if (bus_rd) begin
      if (variant == 9) bus_rdata <= 8'hFF;
      else case (bus_addr)
        3'd1: bus_rdata <= (variant != 10 && m_line[7]) ? m_div : m_ien;
        3'd2: bus_rdata <= ident_of(variant);
        3'd4: bus_rdata <= m_modm;
        3'd7: bus_rdata <= (variant == 1) ? 8'hFF :
                           ((variant == 6 && m_line == 8'hBF) ? 8'h00 : m_scr);
        default: bus_rdata <= 8'h00;
      endcase
    end else bus_rdata <= 8'h00;
  end

  function automatic int expect_code(input int v);
    case (v)
      9, 10: return 0;
      11: return 3;
      12: return 2;
      default: return v;
    endcase
  endfunction

  function automatic string req_of(input int v);
    case (v)
      9: return "R3";
      10: return "R4";
      1: return "R5";
      6: return "R6";
      4, 5: return "R8";
      default: return "R7";
    endcase
  endfunction

  function automatic int reads_needed(input int v);
    case (v)
      9: return 1;
      10: return 2;
      1: return 3;
      6: return 4;
      4, 5: return 6;
      default: return 5;
    endcase
  endfunction

  // op list from R2: kind 1 write, 2 read, 0 idle; packed as kind<<12|addr<<8|data
  function automatic int step_op(input int s);
    case (s)
      0: return 1*4096 + 1*256 + 8'h00;
      1: return 1*4096 + 3*256 + 8'h80;
      2: return 1*4096 + 1*256 + 8'h5A;
      3: return 2*4096 + 1*256;
      4: return 1*4096 + 3*256 + 8'h00;
      5: return 2*4096 + 1*256;
      6: return 1*4096 + 7*256 + 8'h5A;
      7: return 2*4096 + 7*256;
      8: return 1*4096 + 3*256 + 8'hBF;
      9: return 2*4096 + 7*256;
      10: return 1*4096 + 3*256 + 8'h80;
      11: return 1*4096 + 2*256 + 8'hE7;
      12: return 2*4096 + 2*256;
      13: return 1*4096 + 4*256 + 8'h20;
      default: return 2*4096 + 4*256;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // snapshot {busy,done,rd,wr,addr,wdata,type}
  function automatic logic [23:0] snap();
    return {5'd0, busy, done, bus_rd, bus_wr, bus_addr, bus_wdata, type_out};
  endfunction

  int prev_code = 0;

  task automatic run_probe(input int v, input bit extra_start);
    int q[$];
    int nreads = 0;
    int code = expect_code(v);
    logic [23:0] e;
    for (int s = 0; s < 15 && nreads < reads_needed(v); s++) begin
      int op = step_op(s);
      q.push_back(op);
      if (op / 4096 == 2) begin nreads++; q.push_back(0); end
    end
    variant = v;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < q.size(); i++) begin
      int kind = q[i] / 4096;
      logic [2:0] a = 3'((q[i] / 256) % 16);
      logic [7:0] d = 8'(q[i] % 256);
      e = {5'd0, 1'b1, 1'b0, kind == 2, kind == 1, (kind == 0) ? bus_addr : a,
           (kind == 1) ? d : 8'h00, 4'(prev_code)};
      check(snap() == e, (extra_start && i > 5) ? "R10" : "R2", snap(), e);
      if (extra_start) start = (i == 5);
      @(negedge clk);
    end
    start = 1'b0;
    e = {5'd0, 1'b0, 1'b1, 1'b0, 1'b0, bus_addr, 8'h00, 4'(code)};
    check(snap() == e, req_of(v), snap(), e);
    @(negedge clk);
    e = {5'd0, 1'b0, 1'b0, 1'b0, 1'b0, bus_addr, 8'h00, 4'(code)};
    check(snap() == e, "R9", snap(), e);
    prev_code = code;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, done, bus_rd, bus_wr, type_out} == 8'h00, "R1",
          {16'd0, busy, done, bus_rd, bus_wr, type_out}, 24'd0);
    run_probe(9, 1'b0);
    run_probe(10, 1'b0);
    run_probe(1, 1'b0);
    run_probe(6, 1'b0);
    run_probe(2, 1'b0);
    run_probe(3, 1'b0);
    run_probe(12, 1'b0);
    run_probe(11, 1'b0);
    run_probe(7, 1'b0);
    run_probe(4, 1'b0);
    run_probe(5, 1'b0);
    run_probe(4, 1'b1);
    run_probe(9, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule